// File: doc/BRIEF.md
# 32-Pin GPIO Controller with Interrupt Capture

This block is a register-mapped general-purpose I/O peripheral for 32 pins, organised as four banks of eight. A simple synchronous bus carries a byte address, a write strobe, 16-bit write data and combinational 16-bit read data. Each bank has its own 64-byte window. Bank b sits at byte address b*0x40. Pin n is controlled by bank n/8 at bit n%8.

Each bank holds the following registers:

- a direction register, where 1 makes the pin an input;
- an output value register;
- a synchronised view of the pad level;
- a raw interrupt status;
- an interrupt mask;
- a sticky-mode register.

A non-sticky pin records a rising edge of its synchronised input. A sticky pin keeps its status set for as long as the synchronised input is high. The mask is set through one write address and cleared through another. All masked-status bits from the four banks are ORed into a single interrupt line.

Pad cells, bridging to a standard interconnect, and interrupt-controller logic sit outside the block.

Top module: `gpio32_irq`

## Requirements
- R1: Address bits [7:6] select the bank and bits [5:0] select the register in that bank. Pin n maps to bank n/8, bit n%8, so pin 10 appears as bit 2 of bank 1 (byte address 0x58 for its input level). Register contents occupy read-data bits [7:0], and bits [15:8] always read 0.
- R2: Offset 0x10 is the read/write direction register, where 1 means input. `pin_oe` bit n is the inverse of pin n's direction bit and follows a write one clock later.
- R3: Offset 0x14 is the read/write output value register, and `pin_out` bit n equals its bit n.
- R4: Offset 0x18 reads the pad level after a two-flop synchronizer.
- R5: A non-sticky pin sets its raw status bit (read at offset 0x04) when its synchronised level rises. The bit reads 1 after the third rising clock edge that follows the pad change, and 0 after the first and second edges.
- R6: Writing offset 0x04 clears the raw status bits written as 1. If a new event for the same bit lands in the same clock cycle, the event wins and the bit stays 1.
- R7: Offset 0x20 reads the sticky configuration. Writing it sets the bits written as 1, and 0 bits change nothing. A sticky pin's status is forced to 1 on every clock in which its synchronised level is high, even against a clear write. Once the level is low, a clear write takes effect.
- R8: Offset 0x08 reads the mask. Writing it sets the mask bits written as 1. Writing offset 0x0C clears the mask bits written as 1.
- R9: Offset 0x00 reads raw status AND NOT mask.
- R10: `irq` is 1 exactly when some masked-status bit in any bank is 1.
- R11: Offsets 0x0C, 0x1C, 0x24 through 0x3C, and any offset not listed above read 0. Writes to offsets 0x00 and 0x18, and to unmapped offsets, change no state.
- R12: After reset, every pin is an input, every output value bit is 0, every mask bit is 1, and every sticky and status bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address: bank in [7:6], register offset in [5:0] |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data; bits [7:0] are used |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_oe | output | 32 | Output enable per pin, 1 drives the pad |
| pin_out | output | 32 | Output value per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
A status clear write and a new interrupt event can fall on the same clock edge for the same bit. The bench provokes this with a non-sticky pin: it raises the pad and times a clear write to offset 0x04 so that the write is sampled on the third edge, which is the edge where the synchronised rise is recorded. The bit must still read 1 afterwards. The same collision is then forced on a sticky pin held high, where every clear must lose. A behavioural model updated on every clock judges the read data, the pin vectors and `irq` in every cycle around these collisions.

// File: rtl/gpio32_pkg.sv
// Shared constants and types for the 32-pin GPIO controller.
// Assumes eight pins per bank and a 64-byte register window per bank.
package gpio32_pkg;
    localparam int BANK_W = 8;
    localparam int OFF_W  = 6;

    localparam logic [OFF_W-1:0] OFS_MSTAT = 6'h00;
    localparam logic [OFF_W-1:0] OFS_RAW   = 6'h04;
    localparam logic [OFF_W-1:0] OFS_MSET  = 6'h08;
    localparam logic [OFF_W-1:0] OFS_MCLR  = 6'h0C;
    localparam logic [OFF_W-1:0] OFS_DIR   = 6'h10;
    localparam logic [OFF_W-1:0] OFS_DOUT  = 6'h14;
    localparam logic [OFF_W-1:0] OFS_DIN   = 6'h18;
    localparam logic [OFF_W-1:0] OFS_LVL   = 6'h20;

    typedef struct packed {
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] dout;
        logic [BANK_W-1:0] status;
        logic [BANK_W-1:0] mask;
        logic [BANK_W-1:0] sticky;
    } bank_regs_t;
endpackage

// File: rtl/gpio32_sync.sv
// Multi-stage synchronizer for asynchronous pad levels.
// Assumes STAGES >= 1. Every stage resets to 0.
module gpio32_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio32_bank.sv
// One bank of eight pins: direction, output, mask, sticky mode and status.
// Assumes wr_en is already qualified by the bank select, and that lvl is synchronised.
// Within a cycle, a new status event wins over a clear write to the same bit.
module gpio32_bank
    import gpio32_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [BANK_W-1:0] wr_bits,
    input  logic [BANK_W-1:0] lvl,
    output bank_regs_t        regs,
    output logic [BANK_W-1:0] masked
);
    logic [BANK_W-1:0] lvl_q;
    logic [BANK_W-1:0] hit;
    logic              wr_dir, wr_dout, wr_clr, wr_mset, wr_mclr, wr_stk;

    assign wr_dir  = wr_en && (wr_off == OFS_DIR);
    assign wr_dout = wr_en && (wr_off == OFS_DOUT);
    assign wr_clr  = wr_en && (wr_off == OFS_RAW);
    assign wr_mset = wr_en && (wr_off == OFS_MSET);
    assign wr_mclr = wr_en && (wr_off == OFS_MCLR);
    assign wr_stk  = wr_en && (wr_off == OFS_LVL);

    // Hold the previous synchronised level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    // Event per pin: a rising edge in edge mode, a high level in sticky mode.
    assign hit = (~regs.sticky & lvl & ~lvl_q) | (regs.sticky & lvl);

    // Update the bank registers from bus writes and pin events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs.dir    <= '1;
            regs.dout   <= '0;
            regs.status <= '0;
            regs.mask   <= '1;
            regs.sticky <= '0;
        end else begin
            if (wr_dir)  regs.dir  <= wr_bits;
            if (wr_dout) regs.dout <= wr_bits;
            regs.status <= (regs.status & ~(wr_clr ? wr_bits : '0)) | hit;
            if (wr_mset)      regs.mask <= regs.mask | wr_bits;
            else if (wr_mclr) regs.mask <= regs.mask & ~wr_bits;
            if (wr_stk)  regs.sticky <= regs.sticky | wr_bits;
        end
    end

    assign masked = regs.status & ~regs.mask;

    AST_DIR_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_dir |=> (regs.dir == $past(wr_bits))); // R2
    AST_CLEAR_UNLESS_HIT: assert property (@(posedge clk) disable iff (!rst_n) wr_clr |=> ((regs.status & $past(wr_bits & ~hit)) == '0)); // R6
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (|(regs.sticky & lvl)) |=> (($past(regs.sticky & lvl) & ~regs.status) == '0)); // R7
    AST_STICKY_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !wr_stk |=> $stable(regs.sticky)); // R7
    AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n) wr_mset |=> (($past(wr_bits) & ~regs.mask) == '0)); // R8
    AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wr_mclr |=> (($past(wr_bits) & regs.mask) == '0)); // R8
endmodule

// File: rtl/gpio32_rdmux.sv
// Combinational read-data selection across the banks.
// Assumes NBANK is a power of two. Write-only and unmapped offsets return zero.
module gpio32_rdmux
    import gpio32_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int DATA_W = 16
) (
    input  logic [$clog2(NBANK)+OFF_W-1:0]   addr,
    input  bank_regs_t [NBANK-1:0]           regs,
    input  logic [NBANK-1:0][BANK_W-1:0]     masked,
    input  logic [NBANK-1:0][BANK_W-1:0]     lvl,
    output logic [DATA_W-1:0]                rdata
);
    localparam int BSEL_W = $clog2(NBANK);

    logic [BSEL_W-1:0] bsel;
    logic [OFF_W-1:0]  off;
    logic [BANK_W-1:0] sel;
    bank_regs_t        cur;

    // Pick the addressed bank, then the addressed register within it.
    always_comb begin
        bsel = addr[OFF_W +: BSEL_W];
        off  = addr[OFF_W-1:0];
        cur  = regs[bsel];
        case (off)
            OFS_MSTAT: sel = masked[bsel];
            OFS_RAW:   sel = cur.status;
            OFS_MSET:  sel = cur.mask;
            OFS_DIR:   sel = cur.dir;
            OFS_DOUT:  sel = cur.dout;
            OFS_DIN:   sel = lvl[bsel];
            OFS_LVL:   sel = cur.sticky;
            default:   sel = '0;
        endcase
        rdata = DATA_W'(sel);
    end
endmodule

// File: rtl/gpio32_irq.sv
// Top level of the GPIO controller: synchronizer, one register bank per
// group of eight pins, read multiplexer, and the combined interrupt.
// Assumes NBANK is a power of two >= 2 and DATA_W >= 8. bus_rdata is combinational.
module gpio32_irq
    import gpio32_pkg::*;
#(
    parameter int NBANK       = 4,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(NBANK)+OFF_W-1:0]  bus_addr,
    input  logic                            bus_we,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    input  logic [NBANK*BANK_W-1:0]         pin_in,
    output logic [NBANK*BANK_W-1:0]         pin_oe,
    output logic [NBANK*BANK_W-1:0]         pin_out,
    output logic                            irq
);
    localparam int BSEL_W = $clog2(NBANK);
    localparam int NPIN   = NBANK * BANK_W;

    logic [NPIN-1:0]              lvl;
    bank_regs_t [NBANK-1:0]       regs;
    logic [NBANK-1:0][BANK_W-1:0] masked;
    logic [BSEL_W-1:0]            bsel;
    logic                         unused_hi;

    assign bsel      = bus_addr[OFF_W +: BSEL_W];
    assign unused_hi = ^bus_wdata[DATA_W-1:BANK_W];

    gpio32_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpio32_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we && (bsel == BSEL_W'(b))),
            .wr_off  (bus_addr[OFF_W-1:0]),
            .wr_bits (bus_wdata[BANK_W-1:0]),
            .lvl     (lvl[b*BANK_W +: BANK_W]),
            .regs    (regs[b]),
            .masked  (masked[b])
        );
        assign pin_oe[b*BANK_W +: BANK_W]  = ~regs[b].dir;
        assign pin_out[b*BANK_W +: BANK_W] = regs[b].dout;
    end

    gpio32_rdmux #(.NBANK(NBANK), .DATA_W(DATA_W)) u_rd (
        .addr   (bus_addr),
        .regs   (regs),
        .masked (masked),
        .lvl    (lvl),
        .rdata  (bus_rdata)
    );

    assign irq = |masked;

    AST_IRQ_FROM_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> ($past(bus_we) || (|lvl) || (|$past(lvl)))); // R10
endmodule

// File: tb/sim_gpio32_irq.sv
module sim_gpio32_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe, pin_out;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;

    // Reference state
    logic [31:0] m_dir, m_dout, m_stat, m_mask, m_stk, m_s1, m_s2, m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio32_irq u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
    );

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        logic [31:0] wm, hit, clr, bankm;
        int b;
        logic [5:0] off;
        if (!rst_n) begin
            m_dir = '1; m_dout = '0; m_stat = '0; m_mask = '1; m_stk = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            b     = int'(bus_addr[7:6]);
            off   = bus_addr[5:0];
            wm    = {24'h0, bus_wdata[7:0]} << (8*b);
            bankm = 32'hFF << (8*b);
            hit   = (~m_stk & m_s2 & ~m_prev) | (m_stk & m_s2);
            clr   = (bus_we && off == 6'h04) ? wm : 32'h0;
            m_stat = (m_stat & ~clr) | hit;
            if (bus_we && off == 6'h10) m_dir  = (m_dir & ~bankm) | wm;
            if (bus_we && off == 6'h14) m_dout = (m_dout & ~bankm) | wm;
            if (bus_we && off == 6'h08) m_mask = m_mask | wm;
            if (bus_we && off == 6'h0C) m_mask = m_mask & ~wm;
            if (bus_we && off == 6'h20) m_stk  = m_stk | wm;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_in;
        end
    end

    function automatic logic [15:0] exp_rd(input logic [7:0] a);
        int sh;
        logic [31:0] v;
        sh = 8 * int'(a[7:6]);
        case (a[5:0])
            6'h00:   v = (m_stat & ~m_mask) >> sh;
            6'h04:   v = m_stat >> sh;
            6'h08:   v = m_mask >> sh;
            6'h10:   v = m_dir >> sh;
            6'h14:   v = m_dout >> sh;
            6'h18:   v = m_s2 >> sh;
            6'h20:   v = m_stk >> sh;
            default: v = '0;
        endcase
        return {8'h00, v[7:0]};
    endfunction

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference, between edges
    always @(posedge clk) begin
        if (chk_on) begin
            #2;
            cmp(pin_oe, ~m_dir, "R2 pin_oe per cycle");
            cmp(pin_out, m_dout, "R3 pin_out per cycle");
            cmp({31'h0, irq}, {31'h0, |(m_stat & ~m_mask)}, "R10 irq per cycle");
            cmp({16'h0, bus_rdata}, {16'h0, exp_rd(bus_addr)}, "R1 rdata per cycle");
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [15:0] e, input string what);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #2;
        cmp({16'h0, bus_rdata}, {16'h0, e}, what);
    endtask

    task automatic pinchk(input logic [31:0] act_sel, input logic [31:0] e, input string what);
        cmp(act_sel, e, what);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_on = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        chk(8'h10, 16'h00FF, "R12 direction after reset");
        chk(8'h08, 16'h00FF, "R12 mask after reset");
        chk(8'h14, 16'h0000, "R12 output after reset");
        chk(8'hC4, 16'h0000, "R12 status after reset");
        chk(8'hE0, 16'h0000, "R12 sticky after reset");
        pinchk(pin_oe, 32'h0, "R12 pin_oe after reset");

        // R2 direction
        wr(8'h50, 16'h00F0);
        @(negedge clk); #2;
        pinchk(pin_oe, 32'h00000F00, "R2 bank1 low nibble outputs");
        chk(8'h50, 16'h00F0, "R2 direction readback");

        // R3 output, R1 upper byte
        wr(8'h54, 16'hFF05);
        @(negedge clk); #2;
        pinchk(pin_out, 32'h00000500, "R3 pin_out");
        chk(8'h54, 16'h0005, "R1 upper byte reads zero");

        // R4 / R1 input sampling and mapping
        @(negedge clk);
        pin_in = 32'hA500_0400;
        repeat (3) @(negedge clk);
        chk(8'h58, 16'h0004, "R1 pin 10 is bank1 bit2");
        chk(8'hD8, 16'h00A5, "R4 bank3 input level");
        wr(8'hD8, 16'h0000);
        chk(8'hD8, 16'h00A5, "R11 input register ignores writes");

        // R5 edge capture, R9 masked view, R10
        chk(8'hC4, 16'h00A5, "R5 bank3 rising edges captured");
        chk(8'h44, 16'h0004, "R5 bank1 pin 10 captured");
        chk(8'hC0, 16'h0000, "R9 all masked");
        pinchk({31'h0, irq}, 32'h0, "R10 irq low while masked");

        // R8 unmask, R9, R10
        wr(8'hCC, 16'h0001);
        chk(8'hC8, 16'h00FE, "R8 unmask bit0");
        chk(8'hC0, 16'h0001, "R9 masked status");
        pinchk({31'h0, irq}, 32'h1, "R10 irq high");
        chk(8'hCC, 16'h0000, "R11 unmask address reads zero");

        // R6 clear
        wr(8'hC4, 16'h0001);
        chk(8'hC4, 16'h00A4, "R6 clear bit0");
        pinchk({31'h0, irq}, 32'h0, "R10 irq low after clear");

        // R7 sticky
        wr(8'hE0, 16'h0001);
        chk(8'hC4, 16'h00A5, "R7 sticky level re-asserts");
        wr(8'hC4, 16'h0001);
        chk(8'hC4, 16'h00A5, "R7 status held through clear");
        wr(8'hE0, 16'h0000);
        chk(8'hE0, 16'h0001, "R7 zero bits leave sticky unchanged");
        @(negedge clk);
        pin_in = 32'hA400_0400;
        repeat (4) @(negedge clk);
        wr(8'hC4, 16'h0001);
        chk(8'hC4, 16'h00A4, "R7 clear after level drops");
        pinchk({31'h0, irq}, 32'h0, "R10 irq low after release");

        // R8 mask set
        wr(8'hC8, 16'h00FF);
        chk(8'hC8, 16'h00FF, "R8 mask set");

        // R11 unmapped and read-only
        chk(8'h1C, 16'h0000, "R11 offset 0x1C reads zero");
        chk(8'h3C, 16'h0000, "R11 offset 0x3C reads zero");
        wr(8'h00, 16'h00FF);
        wr(8'h24, 16'h00FF);
        wr(8'h18, 16'h00FF);
        chk(8'h08, 16'h00FF, "R11 mask untouched");
        chk(8'h10, 16'h00FF, "R11 direction untouched");
        chk(8'h14, 16'h0000, "R11 output untouched");
        chk(8'h20, 16'h0000, "R11 sticky untouched");
        chk(8'h04, 16'h0000, "R11 status untouched");

        // R5 latency: pad change to status on third edge
        @(negedge clk);
        pin_in = 32'hA400_0401;
        chk(8'h04, 16'h0000, "R5 not after first edge");
        chk(8'h04, 16'h0000, "R5 not after second edge");
        chk(8'h04, 16'h0001, "R5 set after third edge");

        // R6 clear and event on the same edge: event wins
        @(negedge clk);
        pin_in = 32'hA400_0403;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 8'h04; bus_we = 1'b1; bus_wdata = 16'h0002;
        @(negedge clk);
        bus_we = 1'b0;
        #2;
        cmp({16'h0, bus_rdata}, 32'h0000_0003, "R6 event wins over clear");
        wr(8'h04, 16'h0003);
        chk(8'h04, 16'h0000, "R6 clear after collision");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule